// File: doc/BRIEF.md
# DDR Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface and runs the power-up procedure that must finish before the memory can take normal traffic. After reset it holds the clock enable low for the required settling time. It then raises clock enable and issues a fixed list of commands. First comes an extended mode write that turns the delay-locked loop on. Next is a mode write that resets the loop, and the block waits for the loop to lock. A precharge of every bank follows, then a run of auto refreshes, then a final mode write carrying the operating burst length, burst order and CAS latency. Every gap between commands is a minimum delay expressed in clock cycles and derived from parameters. The power-up wait is computed from the clock period.

When the last gap has elapsed, the block raises a done flag and keeps it high. From then on the normal command scheduler owns the bus. The outputs are registered and can be muxed straight onto the memory command pins.

Top module: `ddr_init_seq`

## Requirements
- R1: From reset until clock enable rises, `cke_o` is 0 and the command is NOP. Clock enable rises on the PWR-th clock edge after reset is released, where PWR = ceil(POWERUP_NS*1000 / CLK_PERIOD_PS).
- R2: Once high, `cke_o` never falls again. The first command is issued exactly one cycle after `cke_o` rises.
- R3: The first command is a mode write (code 0000) with bank = 01 and every address bit 0. This enables the delay-locked loop with normal drive strength.
- R4: Exactly TMRD_CYC (2) cycles later, a mode write with bank = 00 is issued. Its address is the operating mode word with A8 = 1, which resets the delay-locked loop.
- R5: Exactly max(TMRD_CYC, DLL_LOCK_CYC) cycles after the loop-reset write, a precharge-all is issued: code 0010, A10 = 1, every other address and bank bit 0.
- R6: NUM_REF auto refreshes (code 0001, bank and address 0) follow. The first comes TRP_CYC cycles after the precharge, and each later one comes TRFC_CYC cycles after the previous one.
- R7: TRFC_CYC cycles after the last refresh, a mode write with bank = 00 carries the operating mode word with A8 = 0.
- R8: Mode word layout: A2..A0 = 001, 010 or 011 for a burst of 2, 4 or 8. A3 = 1 selects interleaved order and 0 selects sequential. A6..A4 = 011 for CAS latency 3 and 100 for CAS latency 4. A7 = 0, and all bits above A8 are 0.
- R9: The command output is {cs_n, ras_n, cas_n, we_n}. On every cycle that is not one of the command cycles above, it is NOP (0111) with bank and address 0.
- R10: `init_done_o` rises exactly TMRD_CYC cycles after the final mode write and then stays high, with NOP on the command output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_o | output | 1 | Clock enable to the memory |
| cmd_n_o | output | 4 | Command code {cs_n, ras_n, cas_n, we_n} |
| bank_o | output | 2 | Bank select bits |
| addr_o | output | 12 | Address bits |
| init_done_o | output | 1 | Initialization complete, sticky |

## Verification
Two things can land on the same edge. One is a gap countdown running out while the step changes and the next command is issued. The other is the final mode-write gap ending on the same edge where the done flag rises. The bench makes these collide by using a short precharge delay and a short refresh delay, so the refresh loop advances to the final mode write on the same edge its counter expires. A scoreboard holds the expected command for each exact cycle, and any command in a cycle where none was expected is a failure. The done flag and clock enable are compared against their expected rise cycles on every cycle, so an edge that comes one cycle early or late is reported.

// File: rtl/ddrinit_pkg.sv
// Package: shared command codes and step encoding for the power-up sequencer.
// Assumes command codes are {cs_n, ras_n, cas_n, we_n}.
package ddrinit_pkg;

    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } ddr_cmd_e;

    typedef enum logic [2:0] {
        ST_PWR,
        ST_EMRS,
        ST_MRS_DLL,
        ST_PALL,
        ST_REF,
        ST_MRS_OP,
        ST_DONE
    } init_step_e;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddrinit_gap_timer.sv
// Module: down-counter that times the minimum gap after each step.
// Loading N makes expired_o high N edges later; reset preloads RESET_VAL.
// Assumes load_i is only asserted while expired_o is high.
module ddrinit_gap_timer #(
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned RESET_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    // Count down to zero, reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RESET_VAL);
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Gap is over when the count reaches zero.
    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/ddrinit_mode_word.sv
// Module: builds the mode register word from the operating parameters.
// Assumes ADDR_W >= 9, BURST_LEN in {2,4,8} and CAS_LAT in {3,4}.
module ddrinit_mode_word #(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned BURST_LEN  = 4,
    parameter bit          INTERLEAVE = 1'b0,
    parameter int unsigned CAS_LAT    = 3
) (
    input  logic              dll_reset_i,
    output logic [ADDR_W-1:0] word_o
);
    localparam logic [2:0] BL_CODE = (BURST_LEN == 2) ? 3'b001 :
                                     (BURST_LEN == 4) ? 3'b010 : 3'b011;
    localparam logic [2:0] CL_CODE = (CAS_LAT == 3) ? 3'b011 : 3'b100;

    // Assemble burst, order, latency and loop-reset fields; test bits stay 0.
    always_comb begin
        word_o      = '0;
        word_o[2:0] = BL_CODE;
        word_o[3]   = INTERLEAVE;
        word_o[6:4] = CL_CODE;
        word_o[8]   = dll_reset_i;
    end

endmodule

// File: rtl/ddr_init_seq.sv
// Module: DDR power-up initialization sequencer (top).
// Holds CKE low for the settling time, raises it, then issues extended mode
// write, loop-reset mode write, precharge-all, NUM_REF refreshes and the
// operating mode write, each followed by its own minimum gap, then raises
// a sticky done flag. All outputs are registered.
// Assumes all gap parameters are at least 1 and TMRD_CYC is at least 2.
module ddr_init_seq
    import ddrinit_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 20000,
    parameter int unsigned POWERUP_NS    = 200000,
    parameter int unsigned DLL_LOCK_CYC  = 200,
    parameter int unsigned TMRD_CYC      = 2,
    parameter int unsigned TRP_CYC       = 4,
    parameter int unsigned TRFC_CYC      = 15,
    parameter int unsigned NUM_REF       = 2,
    parameter int unsigned BURST_LEN     = 4,
    parameter bit          INTERLEAVE    = 1'b0,
    parameter int unsigned CAS_LAT       = 3,
    parameter int unsigned ADDR_W        = 12,
    parameter int unsigned BANK_W        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              cke_o,
    output logic [3:0]        cmd_n_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              init_done_o
);
    localparam int unsigned PWR_CYC  = ceil_div(POWERUP_NS * 1000, CLK_PERIOD_PS);
    localparam int unsigned DLL_GAP  = max2(TMRD_CYC, DLL_LOCK_CYC);
    localparam int unsigned MAX_GAP  = max2(max2(PWR_CYC, DLL_GAP), max2(TRP_CYC, TRFC_CYC));
    localparam int unsigned CNT_W    = $clog2(MAX_GAP + 1);
    localparam int unsigned REF_W    = $clog2(NUM_REF + 1);
    localparam int unsigned CKE_GAP  = 1;

    init_step_e        step_q;
    logic [REF_W-1:0]  ref_cnt_q;
    logic              expired;
    logic              load;
    logic [CNT_W-1:0]  load_val;
    logic              dll_reset_sel;
    logic [ADDR_W-1:0] mode_word;
    ddr_cmd_e          cmd_q;
    logic              cke_q;
    logic              done_q;
    logic [BANK_W-1:0] bank_q;
    logic [ADDR_W-1:0] addr_q;

    ddrinit_gap_timer #(
        .CNT_W     (CNT_W),
        .RESET_VAL (PWR_CYC - 1)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .expired_o  (expired)
    );

    ddrinit_mode_word #(
        .ADDR_W     (ADDR_W),
        .BURST_LEN  (BURST_LEN),
        .INTERLEAVE (INTERLEAVE),
        .CAS_LAT    (CAS_LAT)
    ) u_mode (
        .dll_reset_i (dll_reset_sel),
        .word_o      (mode_word)
    );

    // Select the gap that follows the action taken in the current step.
    always_comb begin
        load          = expired && (step_q != ST_DONE);
        dll_reset_sel = (step_q == ST_MRS_DLL);
        unique case (step_q)
            ST_PWR:     load_val = CNT_W'(CKE_GAP - 1);
            ST_EMRS:    load_val = CNT_W'(TMRD_CYC - 1);
            ST_MRS_DLL: load_val = CNT_W'(DLL_GAP - 1);
            ST_PALL:    load_val = CNT_W'(TRP_CYC - 1);
            ST_REF:     load_val = CNT_W'(TRFC_CYC - 1);
            ST_MRS_OP:  load_val = CNT_W'(TMRD_CYC - 1);
            default:    load_val = '0;
        endcase
    end

    // Step sequencing and registered command outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q    <= ST_PWR;
            ref_cnt_q <= '0;
            cmd_q     <= CMD_NOP;
            cke_q     <= 1'b0;
            done_q    <= 1'b0;
            bank_q    <= '0;
            addr_q    <= '0;
        end else begin
            cmd_q  <= CMD_NOP;
            bank_q <= '0;
            addr_q <= '0;
            if (expired) begin
                unique case (step_q)
                    ST_PWR: begin
                        cke_q  <= 1'b1;
                        step_q <= ST_EMRS;
                    end
                    ST_EMRS: begin
                        cmd_q  <= CMD_MRS;
                        bank_q <= BANK_W'(1);
                        step_q <= ST_MRS_DLL;
                    end
                    ST_MRS_DLL: begin
                        cmd_q  <= CMD_MRS;
                        addr_q <= mode_word;
                        step_q <= ST_PALL;
                    end
                    ST_PALL: begin
                        cmd_q      <= CMD_PRE;
                        addr_q[10] <= 1'b1;
                        ref_cnt_q  <= '0;
                        step_q     <= ST_REF;
                    end
                    ST_REF: begin
                        cmd_q <= CMD_REF;
                        if (ref_cnt_q == REF_W'(NUM_REF - 1)) begin
                            step_q <= ST_MRS_OP;
                        end else begin
                            ref_cnt_q <= ref_cnt_q + 1'b1;
                        end
                    end
                    ST_MRS_OP: begin
                        cmd_q  <= CMD_MRS;
                        addr_q <= mode_word;
                        step_q <= ST_DONE;
                    end
                    default: begin
                        done_q <= 1'b1;
                    end
                endcase
            end
        end
    end

    assign cke_o       = cke_q;
    assign cmd_n_o     = cmd_q;
    assign bank_o      = bank_q;
    assign addr_o      = addr_q;
    assign init_done_o = done_q;

    // R1: no command may leave while the clock enable is still low.
    a_r1_nop_while_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_o |-> cmd_n_o == CMD_NOP);

    // R2: clock enable never drops once raised.
    a_r2_cke_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cke_o |=> cke_o);

    // R9: a mode write is always followed by at least one idle cycle.
    a_r9_mrs_then_nop: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_n_o == CMD_MRS |=> cmd_n_o == CMD_NOP);

    // R8: an operating-bank mode write never sets the test bit and carries a legal latency.
    a_r8_mode_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_n_o == CMD_MRS && bank_o == '0) |->
        (addr_o[7] == 1'b0 && (addr_o[6:4] == 3'b011 || addr_o[6:4] == 3'b100)));

    // R10: done is sticky and the bus is idle once done.
    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_o |=> init_done_o);
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_o |-> (cmd_n_o == CMD_NOP && cke_o));

    // R5: precharge-all always has A10 set.
    a_r5_pall_a10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_n_o == CMD_PRE |-> addr_o[10]);

endmodule

// File: tb/ddr_init_seq_tb_top.sv
// Bench: scoreboard of expected commands per cycle, compared by a monitor.
module ddr_init_seq_tb_top;
    localparam int unsigned PERIOD_PS = 20000;
    localparam int unsigned PWR_NS    = 200000;
    localparam int unsigned DLL_LOCK  = 200;
    localparam int unsigned TMRD      = 2;
    localparam int unsigned TRP       = 3;
    localparam int unsigned TRFC      = 7;
    localparam int unsigned NREF      = 2;
    localparam int unsigned BL        = 8;
    localparam bit          ILV       = 1'b1;
    localparam int unsigned CL        = 4;
    localparam int          WATCHDOG  = 50000;

    localparam logic [3:0] C_MRS = 4'b0000;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_NOP = 4'b0111;

    typedef struct {
        int         cyc;
        logic [3:0] cmd;
        logic [1:0] bank;
        logic [11:0] addr;
        string      req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke;
    logic [3:0]  cmd_n;
    logic [1:0]  bank;
    logic [11:0] addr;
    logic        done;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   cyc = 0;
    int   t_cke = 0;
    int   t_done = 0;
    bit   mon_on = 1'b0;
    exp_t exp_q[$];

    always #10ns clk = ~clk;

    ddr_init_seq #(
        .CLK_PERIOD_PS (PERIOD_PS),
        .POWERUP_NS    (PWR_NS),
        .DLL_LOCK_CYC  (DLL_LOCK),
        .TMRD_CYC      (TMRD),
        .TRP_CYC       (TRP),
        .TRFC_CYC      (TRFC),
        .NUM_REF       (NREF),
        .BURST_LEN     (BL),
        .INTERLEAVE    (ILV),
        .CAS_LAT       (CL),
        .ADDR_W        (12),
        .BANK_W        (2)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cke_o       (cke),
        .cmd_n_o     (cmd_n),
        .bank_o      (bank),
        .addr_o      (addr),
        .init_done_o (done)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
        end
    endtask

    // R8: mode word built from the stated field layout.
    function automatic logic [11:0] mode_word(input bit dll_rst);
        logic [11:0] w = '0;
        w[2:0] = (BL == 2) ? 3'b001 : (BL == 4) ? 3'b010 : 3'b011;
        w[3]   = ILV;
        w[6:4] = (CL == 3) ? 3'b011 : 3'b100;
        w[8]   = dll_rst;
        return w;
    endfunction

    task automatic push(input int c, input logic [3:0] k, input logic [1:0] b,
                        input logic [11:0] a, input string r);
        exp_t e;
        e.cyc = c; e.cmd = k; e.bank = b; e.addr = a; e.req = r;
        exp_q.push_back(e);
    endtask

    // Driver: builds the expected schedule from the requirements.
    task automatic build_schedule();
        int t;
        int d;
        t = (PWR_NS * 1000 + PERIOD_PS - 1) / PERIOD_PS;
        t_cke = t;                                          // R1
        t = t + 1;            push(t, C_MRS, 2'b01, 12'h000, "R3");
        t = t + TMRD;         push(t, C_MRS, 2'b00, mode_word(1'b1), "R4");
        d = (DLL_LOCK > TMRD) ? DLL_LOCK : TMRD;
        t = t + d;            push(t, C_PRE, 2'b00, 12'h400, "R5");
        t = t + TRP;
        for (int i = 0; i < NREF; i++) begin
            push(t, C_REF, 2'b00, 12'h000, "R6");
            t = t + TRFC;
        end
        push(t, C_MRS, 2'b00, mode_word(1'b0), "R7");
        t_done = t + TMRD;                                  // R10
    endtask

    // Monitor: compares every cycle against the scoreboard and the flag schedule.
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                check(cke == (cyc >= t_cke), "R1", "cke", cke, cyc >= t_cke);
                check(done == (cyc >= t_done), "R10", "done", done, cyc >= t_done);
                if (cmd_n != C_NOP) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R9", "unexpected cmd", cmd_n, C_NOP);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(cyc == e.cyc, e.req, "cycle", cyc, e.cyc);
                        check(cmd_n == e.cmd, e.req, "cmd", cmd_n, e.cmd);
                        check(bank == e.bank, e.req, "bank", bank, e.bank);
                        check(addr == e.addr, e.req, "addr", addr, e.addr);
                    end
                end else begin
                    check(bank == 2'b00 && addr == 12'h000, "R9", "idle bank/addr",
                          {bank, addr}, 0);
                end
            end
        end
    end

    initial begin
        int n;
        build_schedule();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cke == 1'b0, "R1", "reset cke", cke, 0);
        check(cmd_n == C_NOP, "R9", "reset cmd", cmd_n, C_NOP);
        check(done == 1'b0, "R10", "reset done", done, 0);
        rst_n  = 1'b1;
        mon_on = 1'b1;
        n = 0;
        while (!(done && cyc > t_done + 20) && n < WATCHDOG) begin
            @(negedge clk);
            n++;
        end
        if (n >= WATCHDOG) check(1'b0, "R10", "watchdog expired", cyc, t_done);
        mon_on = 1'b0;
        check(exp_q.size() == 0, "R6", "commands missing", exp_q.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule